// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is the slave end of a three-wire serial control link with one return line. The host raises a chip-enable line and clocks in an 8-bit address. The address picks one of three frame kinds: a write of the divider word, a write of the control word, or a read of a status word. A write frame shifts its data into a shadow register. The working registers take the new value only when chip-enable falls, and only if the frame carried a full word. A read frame returns the counter result and a sticky unlock flag on an open-drain data-out line. The block drives that line by asserting a pull-low request.

The serial lines run slowly and have no relation to the system clock. The block synchronises them and detects their edges in the system clock domain. Nothing flows through it as a stream, so every pin is a plain level or pulse and there is no back-pressure. The block drives the output ports as pull-low requests. When the time-base option is enabled, the first port carries a free-running clock with 40% high time in place of its programmed bit. A one-cycle acknowledge marks each read frame that was clocked to completion, and a status counter can use it to restart.

Top module: `scp_ctl_port`

## Requirements
- R1: The address is 8 bits, sent LSB first and sampled on rising `ser_clk` while `ser_ce` is high. 0x28 selects the divider write, 0x29 selects the control write and 0x2A selects the status read. A frame with any other address changes no output and does not clear the unlock flag.
- R2: Write data is 16 bits, sent LSB first on rising `ser_clk`. The working registers change only after `ser_ce` falls and never while the frame is still open.
- R3: A write frame that ends with fewer than 16 data bits is discarded. Bits clocked after the 16th are ignored.
- R4: In the control word, bits [3:0] are the port pull-low bits (1 = pull low), bit 4 is time-base enable, bits [7:5] select the data-out function, bits [9:8] are `gate_sel` and bit 10 is `cnt_en`. Bits [15:11] are ignored.
- R5: After reset, `divisor`, `gate_sel`, `cnt_en` and `port_low` are all 0, so every port is open, and `dout_low` is 0.
- R6: A read returns 24 bits LSB first. Bits [19:0] hold `count_val`, bit 20 holds the unlock flag and bits [23:21] are 0, all captured when the address is decoded. Each bit is driven after a falling `ser_clk` edge, the first one after the 8th address clock, so the host samples on rising edges.
- R7: A pulse on `unlock_evt` sets the unlock flag. The flag then stays set until a transfer completes, which means a committed write or a read clocked to all 24 bits. If an event and a completion arrive in the same cycle, the flag is set.
- R8: `rd_ack` pulses for exactly one cycle after `ser_ce` falls at the end of a read frame that was clocked through all 24 bits. An aborted read gives no pulse.
- R9: With time-base enabled, `port_low[0]` is released for 2/5 of every `TB_PERIOD` cycles and pulled low for the rest, and the programmed bit 0 is ignored. With time-base disabled, it follows programmed bit 0.
- R10: Outside a read frame, `dout_low` follows the function select. 0 releases the line, 1 pulls it low while the unlock flag is set, 2 pulls it low while `count_done` is high, and any other value releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_ce | input | 1 | Serial chip-enable, high during a frame |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data from host |
| dout_low | output | 1 | Pull-low request for the open-drain data-out line |
| count_val | input | 20 | Counter result reported in reads |
| count_done | input | 1 | Counter finished flag, viewable on data-out |
| unlock_evt | input | 1 | One-cycle unlock detection event |
| divisor | output | 16 | Committed divider word |
| port_low | output | 4 | Output port pull-low requests |
| gate_sel | output | 2 | Committed counter gate selection |
| cnt_en | output | 1 | Committed counter enable |
| rd_ack | output | 1 | One-cycle pulse per completed read frame |

## Verification
The bench aims at the frame boundaries. It checks a write whose sixteen bits have arrived while chip-enable is still high, which a design committing on the last bit would expose early. It sends a frame cut short, which a design committing partial words would let corrupt the divider. It sends one clocked past sixteen bits, which a design that keeps shifting would misalign. It also sends an unknown address, which sloppy decoding would treat as a write. It holds the unlock flag across ignored and aborted frames and then reads it, so that clearing too early or not at all changes both the returned bit 20 and the data-out level. It times the read bits against falling edges, counts acknowledge pulses through a cut-short read, and measures the high time of the time-base wave over one full period.

// File: rtl/scp_ctl_port_pkg.sv
package scp_ctl_port_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WR_A,
    PH_WR_B,
    PH_RD,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/scp_edge_sync.sv
module scp_edge_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign level = stg[STAGES-1];
  assign rise  = stg[STAGES-1] & ~prev;
  assign fall  = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/scp_frame_rx.sv
module scp_frame_rx
  import scp_ctl_port_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter int          RD_W    = 24,
  parameter logic [7:0]  ADDR_A  = 8'h28,
  parameter logic [7:0]  ADDR_B  = 8'h29,
  parameter logic [7:0]  ADDR_RD = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_lvl,
  input  logic              ce_rise,
  input  logic              ce_fall,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              commit_a,
  output logic              commit_b,
  output logic              rd_start,
  output logic              rd_done,
  output logic              xfer_done
);
  localparam int MAXB = (WORD_W > RD_W) ? WORD_W : RD_W;
  localparam int BC_W = $clog2(MAXB + 1);
  localparam logic [BC_W-1:0] WORD_FULL = BC_W'(WORD_W);
  localparam logic [BC_W-1:0] RD_FULL   = BC_W'(RD_W);

  phase_e            phase;
  logic [7:0]        addr_sr, addr_nx;
  logic [2:0]        acnt;
  logic [BC_W-1:0]   bcnt;
  logic [WORD_W-1:0] sr;
  phase_e            dec_ph;

  assign addr_nx = {din, addr_sr[7:1]};

  always_comb begin
    if      (addr_nx == ADDR_A)  dec_ph = PH_WR_A;
    else if (addr_nx == ADDR_B)  dec_ph = PH_WR_B;
    else if (addr_nx == ADDR_RD) dec_ph = PH_RD;
    else                         dec_ph = PH_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      addr_sr   <= '0;
      acnt      <= '0;
      bcnt      <= '0;
      sr        <= '0;
      commit_a  <= 1'b0;
      commit_b  <= 1'b0;
      rd_start  <= 1'b0;
      rd_done   <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      commit_a  <= 1'b0;
      commit_b  <= 1'b0;
      rd_start  <= 1'b0;
      rd_done   <= 1'b0;
      xfer_done <= 1'b0;
      if (ce_rise) begin
        phase <= PH_ADDR;
        acnt  <= '0;
        bcnt  <= '0;
      end else if (ce_fall) begin
        case (phase)
          PH_WR_A: if (bcnt == WORD_FULL) begin
            commit_a  <= 1'b1;
            xfer_done <= 1'b1;
          end
          PH_WR_B: if (bcnt == WORD_FULL) begin
            commit_b  <= 1'b1;
            xfer_done <= 1'b1;
          end
          PH_RD: if (bcnt == RD_FULL) begin
            rd_done   <= 1'b1;
            xfer_done <= 1'b1;
          end
          default: ;
        endcase
        phase <= PH_IDLE;
      end else if (sclk_rise && ce_lvl) begin
        case (phase)
          PH_ADDR: begin
            addr_sr <= addr_nx;
            acnt    <= acnt + 3'd1;
            if (acnt == 3'd7) begin
              phase    <= dec_ph;
              rd_start <= (dec_ph == PH_RD);
            end
          end
          PH_WR_A, PH_WR_B: if (bcnt < WORD_FULL) begin
            sr   <= {din, sr[WORD_W-1:1]};
            bcnt <= bcnt + 1'b1;
          end
          PH_RD: if (bcnt < RD_FULL) bcnt <= bcnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign word = sr;
endmodule

// File: rtl/scp_readout.sv
module scp_readout #(
  parameter int CNT_W = 20,
  parameter int RD_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start,
  input  logic             ce_fall,
  input  logic             sclk_fall,
  input  logic             xfer_done,
  input  logic             unlock_evt,
  input  logic [CNT_W-1:0] count_val,
  input  logic             count_done,
  input  logic [2:0]       dout_sel,
  output logic             unlock_flag,
  output logic             dout_low
);
  localparam int PAD = RD_W - CNT_W - 1;

  logic [RD_W-1:0] tx_sr;
  logic            tx_bit;
  logic            active;
  logic [RD_W-1:0] snap;

  assign snap = {{PAD{1'b0}}, unlock_flag, count_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_flag <= 1'b0;
    end else if (unlock_evt) begin
      unlock_flag <= 1'b1;
    end else if (xfer_done) begin
      unlock_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '1;
      tx_bit <= 1'b1;
      active <= 1'b0;
    end else if (rd_start) begin
      tx_sr  <= snap;
      tx_bit <= 1'b1;
      active <= 1'b1;
    end else if (ce_fall) begin
      tx_bit <= 1'b1;
      active <= 1'b0;
    end else if (active && sclk_fall) begin
      tx_bit <= tx_sr[0];
      tx_sr  <= {1'b1, tx_sr[RD_W-1:1]};
    end
  end

  always_comb begin
    if (active) begin
      dout_low = ~tx_bit;
    end else begin
      case (dout_sel)
        3'd1:    dout_low = unlock_flag;
        3'd2:    dout_low = count_done;
        default: dout_low = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/scp_timebase.sv
module scp_timebase #(
  parameter int PERIOD = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic wave
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HIGH_N = CW'((PERIOD * 2) / 5);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign wave = en && (cnt < HIGH_N);
endmodule

// File: rtl/scp_ctl_port.sv
module scp_ctl_port #(
  parameter int         NPORT       = 4,
  parameter int         CNT_W       = 20,
  parameter int         WORD_W      = 16,
  parameter int         RD_W        = 24,
  parameter logic [7:0] ADDR_A      = 8'h28,
  parameter logic [7:0] ADDR_B      = 8'h29,
  parameter logic [7:0] ADDR_RD     = 8'h2A,
  parameter int         TB_PERIOD   = 1250000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_ce,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              dout_low,
  input  logic [CNT_W-1:0]  count_val,
  input  logic              count_done,
  input  logic              unlock_evt,
  output logic [WORD_W-1:0] divisor,
  output logic [NPORT-1:0]  port_low,
  output logic [1:0]        gate_sel,
  output logic              cnt_en,
  output logic              rd_ack
);
  localparam int F_TB   = NPORT;
  localparam int F_SEL  = NPORT + 1;
  localparam int F_GATE = NPORT + 4;
  localparam int F_CEN  = NPORT + 6;
  localparam int F_END  = NPORT + 7;

  logic [2:0] lvl, rise, fall;
  logic       ce_lvl;
  logic [WORD_W-1:0] wr_word;
  logic commit_a, commit_b, rd_start, xfer_done;
  logic unlock_flag;
  logic tb_wave;

  logic [NPORT-1:0] port_q;
  logic             tb_en_q;
  logic [2:0]       sel_q;

  logic unused_sig;
  assign unused_sig = ^{wr_word[WORD_W-1:F_END], rise[0], rise[2], fall[2], fall[1] & 1'b0};

  scp_edge_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_din, ser_clk, ser_ce}),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  assign ce_lvl = lvl[0];

  scp_frame_rx #(
    .WORD_W(WORD_W), .RD_W(RD_W),
    .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .ADDR_RD(ADDR_RD)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl    (ce_lvl),
    .ce_rise   (rise[0]),
    .ce_fall   (fall[0]),
    .sclk_rise (rise[1]),
    .din       (lvl[2]),
    .word      (wr_word),
    .commit_a  (commit_a),
    .commit_b  (commit_b),
    .rd_start  (rd_start),
    .rd_done   (rd_ack),
    .xfer_done (xfer_done)
  );

  scp_readout #(.CNT_W(CNT_W), .RD_W(RD_W)) u_ro (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_start    (rd_start),
    .ce_fall     (fall[0]),
    .sclk_fall   (fall[1]),
    .xfer_done   (xfer_done),
    .unlock_evt  (unlock_evt),
    .count_val   (count_val),
    .count_done  (count_done),
    .dout_sel    (sel_q),
    .unlock_flag (unlock_flag),
    .dout_low    (dout_low)
  );

  scp_timebase #(.PERIOD(TB_PERIOD)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tb_en_q),
    .wave  (tb_wave)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor  <= '0;
      port_q   <= '0;
      tb_en_q  <= 1'b0;
      sel_q    <= '0;
      gate_sel <= '0;
      cnt_en   <= 1'b0;
    end else begin
      if (commit_a) divisor <= wr_word;
      if (commit_b) begin
        port_q   <= wr_word[NPORT-1:0];
        tb_en_q  <= wr_word[F_TB];
        sel_q    <= wr_word[F_SEL +: 3];
        gate_sel <= wr_word[F_GATE +: 2];
        cnt_en   <= wr_word[F_CEN];
      end
    end
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    if (gi == 0) begin : g_tb
      assign port_low[gi] = tb_en_q ? ~tb_wave : port_q[gi];
    end else begin : g_plain
      assign port_low[gi] = port_q[gi];
    end
  end
endmodule

// File: rtl/scp_ctl_port_chk.sv
module scp_ctl_port_chk #(
  parameter int WORD_W = 16,
  parameter int NPORT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_lvl,
  input logic              commit_a,
  input logic              commit_b,
  input logic              xfer_done,
  input logic              unlock_evt,
  input logic              unlock_flag,
  input logic              rd_ack,
  input logic [WORD_W-1:0] divisor,
  input logic [NPORT-1:0]  port_low,
  input logic [1:0]        gate_sel,
  input logic              cnt_en
);
  p_reset_clear_r5: assert property (@(posedge clk)
    !rst_n |=> (divisor == '0 && port_low == '0 && gate_sel == '0 && !cnt_en));

  p_divisor_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_a |=> $stable(divisor));

  p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_b |=> ($stable(gate_sel) && $stable(cnt_en)));

  p_unlock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> unlock_flag);

  p_unlock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_flag && !xfer_done) |=> unlock_flag);

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  p_ack_ce_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !ce_lvl);
endmodule

bind scp_ctl_port scp_ctl_port_chk #(.WORD_W(WORD_W), .NPORT(NPORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_lvl      (ce_lvl),
  .commit_a    (commit_a),
  .commit_b    (commit_b),
  .xfer_done   (xfer_done),
  .unlock_evt  (unlock_evt),
  .unlock_flag (unlock_flag),
  .rd_ack      (rd_ack),
  .divisor     (divisor),
  .port_low    (port_low),
  .gate_sel    (gate_sel),
  .cnt_en      (cnt_en)
);

// File: tb/scp_ctl_port_test.sv
module scp_ctl_port_test;
  localparam int HB = 8;
  localparam logic [7:0] A_DIV = 8'h28, A_CTL = 8'h29, A_RD = 8'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic dout_low;
  logic [19:0] count_val = '0;
  logic count_done = 1'b0, unlock_evt = 1'b0;
  logic [15:0] divisor;
  logic [3:0] port_low;
  logic [1:0] gate_sel;
  logic cnt_en, rd_ack;

  int n_checks = 0, n_fail = 0, ack_cnt = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];
  logic [23:0] rd_word;
  event rd_got;

  always #5 clk = ~clk;

  scp_ctl_port #(.TB_PERIOD(20)) uut (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_din(ser_din),
    .dout_low(dout_low), .count_val(count_val), .count_done(count_done),
    .unlock_evt(unlock_evt), .divisor(divisor), .port_low(port_low),
    .gate_sel(gate_sel), .cnt_en(cnt_en), .rd_ack(rd_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) if (rst_n && rd_ack) ack_cnt++;

  // scoreboard monitor: compares every completed read word to the queue
  initial begin
    forever begin
      @(rd_got);
      if (exp_q.size() == 0) check("R6 unexpected read", {8'h0, rd_word}, 32'hFFFFFFFF);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check("R6 read word", {8'h0, rd_word}, {8'h0, e});
      end
    end
  end

  task automatic bit_out(input logic b);
    ser_din = b;
    wait_cyc(HB);
    ser_clk = 1'b1;
    wait_cyc(HB);
    ser_clk = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] a);
    ser_ce = 1'b1;
    wait_cyc(HB);
    for (int i = 0; i < 8; i++) bit_out(a[i]);
  endtask

  task automatic end_frame();
    wait_cyc(HB);
    ser_ce = 1'b0;
    wait_cyc(10);
  endtask

  task automatic write_frame(input logic [7:0] a, input logic [31:0] w, input int nbits);
    send_addr(a);
    for (int i = 0; i < nbits; i++) bit_out(w[i]);
    end_frame();
  endtask

  task automatic read_frame(input int nbits);
    logic [23:0] w;
    w = '0;
    send_addr(A_RD);
    for (int i = 0; i < nbits; i++) begin
      wait_cyc(HB);
      w[i] = ~dout_low;
      ser_clk = 1'b1;
      wait_cyc(HB);
      ser_clk = 1'b0;
    end
    end_frame();
    if (nbits == 24) begin
      rd_word = w;
      -> rd_got;
    end
  endtask

  task automatic pulse_unlock();
    unlock_evt = 1'b1;
    wait_cyc(1);
    unlock_evt = 1'b0;
    wait_cyc(2);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: actual running expected finished");
          $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    int ack0, lowc;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R5 reset state
    check("R5 divisor", 32'(divisor), 0);
    check("R5 port_low", 32'(port_low), 0);
    check("R5 gate/cnt_en", 32'({gate_sel, cnt_en}), 0);
    check("R5 dout_low", 32'(dout_low), 0);

    // R2: full word in, commit waits for chip-enable fall
    send_addr(A_DIV);
    for (int i = 0; i < 16; i++) bit_out(16'hA5C3 >> i);
    wait_cyc(HB);
    check("R2 no commit while ce high", 32'(divisor), 0);
    ser_ce = 1'b0;
    wait_cyc(10);
    check("R2 R1 divisor committed", 32'(divisor), 32'hA5C3);

    // R4 control word fields
    write_frame(A_CTL, 32'h070A, 16);
    check("R4 port_low", 32'(port_low), 32'hA);
    check("R4 gate_sel", 32'(gate_sel), 3);
    check("R4 cnt_en", 32'(cnt_en), 1);

    // R1 unknown address ignored
    write_frame(8'h2B, 32'h1234, 16);
    check("R1 unknown address", 32'(divisor), 32'hA5C3);

    // R3 aborted and overlong frames
    write_frame(A_DIV, 32'hFFFF, 10);
    check("R3 aborted write", 32'(divisor), 32'hA5C3);
    write_frame(A_DIV, 32'h000F0F0F, 20);
    check("R3 extra bits ignored", 32'(divisor), 32'h0F0F);

    // R10 / R7 unlock flag on data-out
    write_frame(A_CTL, 32'h072A, 16);
    check("R10 sel1 flag clear", 32'(dout_low), 0);
    pulse_unlock();
    check("R7 R10 flag set", 32'(dout_low), 1);
    write_frame(8'h55, 32'h0000, 16);
    check("R1 R7 flag kept after unknown frame", 32'(dout_low), 1);
    write_frame(A_CTL, 32'h0000, 5);
    check("R7 flag kept after aborted write", 32'(dout_low), 1);

    // R6 R8 read with flag set
    count_val = 20'hABCDE;
    ack0 = ack_cnt;
    exp_q.push_back({3'b000, 1'b1, 20'hABCDE});
    read_frame(24);
    check("R8 one ack per read", 32'(ack_cnt - ack0), 1);
    check("R7 flag cleared by read", 32'(dout_low), 0);

    count_val = 20'h12345;
    exp_q.push_back({3'b000, 1'b0, 20'h12345});
    read_frame(24);
    ack0 = ack_cnt;
    read_frame(10);
    check("R8 no ack for aborted read", 32'(ack_cnt - ack0), 0);

    // R10 counter-done view
    write_frame(A_CTL, 32'h074A, 16);
    count_done = 1'b1;
    wait_cyc(2);
    check("R10 sel2 done high", 32'(dout_low), 1);
    count_done = 1'b0;
    wait_cyc(2);
    check("R10 sel2 done low", 32'(dout_low), 0);

    // R9 time base on port 0
    write_frame(A_CTL, 32'h0011, 16);
    lowc = 0;
    for (int i = 0; i < 20; i++) begin
      wait_cyc(1);
      if (port_low[0] == 1'b0) lowc++;
    end
    check("R9 released cycles per period", 32'(lowc), 8);
    check("R9 other ports", 32'(port_low[3:1]), 0);
    write_frame(A_CTL, 32'h0001, 16);
    check("R9 port0 follows bit when off", 32'(port_low), 1);

    wait_cyc(20);
    check("R6 all reads consumed", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule